// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer

This block takes a serial stream that has already been sampled once per bit in the bit-clock domain. It recovers 10-bit words from it. On the line, each word sits inside a 12-bit frame. The first bit is a start bit that is always 1, the ten payload bits follow, and the last bit is a stop bit that is always 0. The stop-to-start transition works as an embedded clock edge, and the block uses it to find where frames begin.

While unlocked, the block hunts by testing the frame boundary at every bit position. Once a position passes the test, it counts consecutive well-framed frames. After the configured number of frames, it declares lock. From then on it presents each payload word with a one-cycle strobe and holds an active-low lock flag low. If the clock bits are wrong in two successive frames, lock is lost and the block goes back to hunting by itself.

The word and strobe outputs have an enable signal for the pad drivers, so the chip can tri-state them. The enable is active only when three conditions hold: the block is locked, the output-enable input is high, and the power input is high. Lowering the power input returns the block to the hunt.

Top module: `frame_deser`

## Requirements
- R1: A frame is accepted when its first bit is 1 and its last bit is 0. The payload bit received right after the start bit appears on `word_out[0]`, and the bit received just before the stop bit appears on `word_out[W-1]`.
- R2: Starting from an idle-low line after reset, the block finds frame alignment at whatever bit offset the first frame arrives on, without any command.
- R3: `lock_n` goes low only after LOCK_FRAMES consecutive well-framed frames, counting the frame that ended the hunt. In that same cycle, `word_stb` pulses and `word_out` carries the last of those frames' payload. One frame fewer leaves `lock_n` high.
- R4: While the block is locked and driving, `word_stb` is high for exactly one cycle per frame, which is once every W+2 bit periods.
- R5: A frame counts as bad when its start bit is 0 or its stop bit is 1. While locked, a single bad frame keeps the lock and still delivers its word. LOSS_MISSES consecutive bad frames drive `lock_n` high in the cycle after the last one is checked.
- R6: `drv_en` is high only when the block is locked, `out_en` is high and `pwr_up` is high. Whenever `drv_en` is low, `word_out` is all zeros and `word_stb` is 0.
- R7: Holding `out_en` low does not change lock or alignment. `lock_n` stays low, and when `out_en` returns high, words continue correctly without relocking.
- R8: When `pwr_up` is low, `lock_n` is high from the next clock edge and the frame counter is cleared. After `pwr_up` returns high, the block needs a full LOCK_FRAMES good frames again.
- R9: After lock is lost, including loss caused by a shift in the stream's bit offset, the block realigns and locks again on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one sample per bit |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Sampled serial bit |
| pwr_up | input | 1 | High: block running. Low: power-down, state cleared |
| out_en | input | 1 | Output enable for the word and strobe pins |
| word_out | output | W | Recovered payload word (zero when not driven) |
| word_stb | output | 1 | One-cycle strobe for each delivered word |
| lock_n | output | 1 | Low while locked |
| drv_en | output | 1 | Tri-state enable for `word_out` and `word_stb` |

## Verification
The bench builds the block with its default parameters: a 10-bit payload, 80 frames to lock and 2 misses to unlock. This makes it possible to check the exact 79-versus-80 lock boundary rather than a shortened one. Because the frame count is the real one, the relock after power-down and after a bit-offset shift each take the full count, and a single bad frame can be tested separately from a pair of them. Zero payloads keep the misaligned windows from looking framed, so the loss-and-realign path runs deterministically.

// File: rtl/frame_deser.sv
module frame_deser #(
  parameter int W           = 10,
  parameter int LOCK_FRAMES = 80,
  parameter int LOSS_MISSES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         pwr_up,
  input  logic         out_en,
  output logic [W-1:0] word_out,
  output logic         word_stb,
  output logic         lock_n,
  output logic         drv_en
);

  localparam int FL = W + 2;
  localparam int PW = $clog2(FL);
  localparam int GW = $clog2(LOCK_FRAMES + 1);
  localparam int MW = $clog2(LOSS_MISSES + 1);

  typedef enum logic [1:0] {HUNT, CONFIRM, LOCKED} st_t;

  st_t           st;
  logic [FL-1:0] sr;
  logic [PW-1:0] ph;
  logic [GW-1:0] good;
  logic [MW-1:0] miss;
  logic          locked_q, stb_q;
  logic [W-1:0]  word_q, payload;

  wire framed  = sr[FL-1] & ~sr[0];
  wire at_edge = (st == HUNT) | (ph == PW'(FL - 1));
  wire [GW-1:0] good_nx = good + 1'b1;
  wire [MW-1:0] miss_nx = miss + 1'b1;

  always_comb
    for (int i = 0; i < W; i++) payload[i] = sr[FL-2-i];

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_up) begin
      st       <= HUNT;
      sr       <= '0;
      ph       <= '0;
      good     <= '0;
      miss     <= '0;
      locked_q <= 1'b0;
      stb_q    <= 1'b0;
      word_q   <= '0;
    end else begin
      sr    <= {sr[FL-2:0], ser_in};
      stb_q <= 1'b0;
      ph    <= (ph == PW'(FL - 1)) ? '0 : ph + 1'b1;
      case (st)
        HUNT, CONFIRM: if (at_edge) begin
          if (framed) begin
            ph <= '0;
            if (good_nx >= GW'(LOCK_FRAMES)) begin
              st       <= LOCKED;
              locked_q <= 1'b1;
              stb_q    <= 1'b1;
              word_q   <= payload;
              good     <= '0;
            end else begin
              st   <= CONFIRM;
              good <= good_nx;
            end
          end else begin
            st   <= HUNT;
            good <= '0;
          end
        end
        LOCKED: if (at_edge) begin
          if (framed) begin
            miss   <= '0;
            stb_q  <= 1'b1;
            word_q <= payload;
          end else if (miss_nx >= MW'(LOSS_MISSES)) begin
            st       <= HUNT;
            locked_q <= 1'b0;
            miss     <= '0;
          end else begin
            miss   <= miss_nx;
            stb_q  <= 1'b1;
            word_q <= payload;
          end
        end
        default: st <= HUNT;
      endcase
    end
  end

  assign drv_en   = locked_q & out_en & pwr_up;
  assign lock_n   = ~locked_q;
  assign word_out = drv_en ? word_q : '0;
  assign word_stb = drv_en & stb_q;

endmodule

// File: rtl/frame_deser_chk.sv
module frame_deser_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_up,
  input logic         out_en,
  input logic [W-1:0] word_out,
  input logic         word_stb,
  input logic         lock_n,
  input logic         drv_en
);

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_n |-> (!drv_en && !word_stb && word_out == '0));

  assert_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!drv_en && !word_stb));

  assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);

  assert_lock_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_n) && out_en && pwr_up) |-> word_stb);

  assert_pwr_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> lock_n);

endmodule

bind frame_deser frame_deser_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .out_en(out_en),
  .word_out(word_out), .word_stb(word_stb), .lock_n(lock_n), .drv_en(drv_en)
);

// File: tb/tb_frame_deser.sv
module tb_frame_deser;
  localparam int W = 10;
  localparam int LOCKN = 80;
  localparam int MISSN = 2;

  logic clk = 0, rst_n = 0, ser_in = 0, pwr_up = 1, out_en = 1;
  logic [W-1:0] word_out;
  logic word_stb, lock_n, drv_en;

  frame_deser #(.W(W), .LOCK_FRAMES(LOCKN), .LOSS_MISSES(MISSN)) dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .pwr_up(pwr_up), .out_en(out_en),
    .word_out(word_out), .word_stb(word_stb), .lock_n(lock_n), .drv_en(drv_en));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, stb_cnt = 0;
  bit done = 0, saw_unlock = 0, model_on = 0;
  logic prev_lock_n, prev_stb;
  logic [W-1:0] prev_word;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: frame state, counts and outputs from the requirements
  bit hist[W+2];
  int m_st = 0, m_ph = 0, m_good = 0, m_miss = 0;
  bit m_lock = 0, m_stb = 0, fr, edge_now;
  logic [W-1:0] m_word = '0, pay;

  always @(posedge clk) begin
    if (!rst_n || !pwr_up) begin
      foreach (hist[i]) hist[i] = 0;
      m_st = 0; m_ph = 0; m_good = 0; m_miss = 0;
      m_lock = 0; m_stb = 0; m_word = '0;
    end else begin
      fr = hist[W+1] && !hist[0];
      for (int i = 0; i < W; i++) pay[i] = hist[W-i];
      edge_now = (m_st == 0) || (m_ph == W+1);
      m_stb = 0;
      m_ph = (m_ph == W+1) ? 0 : m_ph + 1;
      if (m_st != 2) begin
        if (edge_now) begin
          if (fr) begin
            m_ph = 0;
            if (m_good + 1 >= LOCKN) begin
              m_st = 2; m_lock = 1; m_stb = 1; m_word = pay; m_good = 0;
            end else begin
              m_st = 1; m_good = m_good + 1;
            end
          end else begin
            m_st = 0; m_good = 0;
          end
        end
      end else if (edge_now) begin
        if (fr) begin
          m_miss = 0; m_stb = 1; m_word = pay;
        end else if (m_miss + 1 >= MISSN) begin
          m_st = 0; m_lock = 0; m_miss = 0;
        end else begin
          m_miss = m_miss + 1; m_stb = 1; m_word = pay;
        end
      end
      for (int i = W+1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = ser_in;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit drv;
      drv = m_lock && out_en && pwr_up;
      chk("R3 R5 model lock_n", lock_n, !m_lock);
      chk("R6 model drv_en", drv_en, drv);
      chk("R4 model word_stb", word_stb, drv && m_stb);
      chk("R1 model word_out", word_out, drv ? m_word : '0);
    end
    if (word_stb) stb_cnt++;
    if (lock_n) saw_unlock = 1;
  end

  task automatic send_frame(input logic [W-1:0] d, input bit bad);
    for (int k = 0; k < W+2; k++) begin
      if (k == 0) ser_in = 1'b1;
      else if (k == W+1) ser_in = bad;
      else ser_in = d[k-1];
      @(negedge clk);
      if (k == 0) begin
        prev_lock_n = lock_n; prev_stb = word_stb; prev_word = word_out;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] last;
    repeat (3) @(negedge clk);
    model_on = 1;
    chk("R6 reset lock_n", lock_n, 1);
    chk("R6 reset drv_en", drv_en, 0);
    chk("R6 reset word_out", word_out, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);                      // R2: arbitrary offset
    for (int f = 1; f <= LOCKN; f++) begin
      last = W'(f * 37 + 5);
      send_frame(last, 0);
      if (f == LOCKN) chk("R3 not locked after 79 frames", prev_lock_n, 1);
    end
    send_frame(10'h001, 0);
    chk("R3 lock after 80 frames", prev_lock_n, 0);
    chk("R3 strobe with lock", prev_stb, 1);
    chk("R2 R3 first word", prev_word, last);
    send_frame(10'h200, 0);
    chk("R1 first data bit to bit 0", prev_word, 10'h001);
    send_frame(10'h155, 0);
    chk("R1 last data bit to top bit", prev_word, 10'h200);
    stb_cnt = 0;
    for (int f = 0; f < 10; f++) send_frame(W'(f * 91), 0);
    chk("R4 one strobe per frame", stb_cnt, 10);
    // single miss tolerated
    send_frame(10'h0F0, 1);
    send_frame(10'h00F, 0);
    chk("R5 single bad frame keeps lock", prev_lock_n, 0);
    chk("R5 single bad frame word", prev_word, 10'h0F0);
    send_frame(10'h3C3, 0);
    chk("R5 lock after recovery", prev_lock_n, 0);
    // out_en low
    out_en = 0;
    stb_cnt = 0;
    send_frame(10'h111, 0);
    chk("R7 drv_en low while out_en low", drv_en, 0);
    send_frame(10'h222, 0);
    chk("R7 lock kept while out_en low", prev_lock_n, 0);
    chk("R7 word pins zero while disabled", prev_word, 0);
    chk("R6 no strobe while disabled", stb_cnt, 0);
    out_en = 1;
    send_frame(10'h2A5, 0);
    send_frame(10'h000, 0);
    chk("R7 words resume after out_en", prev_word, 10'h2A5);
    chk("R7 no relock needed", prev_lock_n, 0);
    // two consecutive misses
    send_frame(10'h000, 1);
    send_frame(10'h000, 1);
    send_frame(10'h000, 0);
    chk("R5 two bad frames drop lock", prev_lock_n, 1);
    for (int f = 0; f < 100; f++) send_frame(10'h000, 0);
    chk("R9 relock after bad frames", prev_lock_n, 0);
    // offset shift
    saw_unlock = 0;
    ser_in = 0;
    repeat (5) @(negedge clk);
    for (int f = 0; f < 100; f++) send_frame(10'h000, 0);
    chk("R9 offset shift drops lock", saw_unlock, 1);
    chk("R9 realigned after shift", prev_lock_n, 0);
    // power down
    pwr_up = 0;
    ser_in = 0;
    @(negedge clk);
    chk("R8 lock_n high in power-down", lock_n, 1);
    chk("R6 drv_en low in power-down", drv_en, 0);
    repeat (2) @(negedge clk);
    pwr_up = 1;
    for (int f = 1; f <= LOCKN; f++) begin
      send_frame(W'(f * 13), 0);
      if (f == LOCKN) chk("R8 full count after power-up", prev_lock_n, 1);
    end
    send_frame(10'h000, 0);
    chk("R8 relock after power-up", prev_lock_n, 0);
    chk("R8 word after power-up", prev_word, W'(LOCKN * 13));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule